// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Unit

This unit multiplies or divides two 32-bit integers over many clock cycles. One shared adder/subtractor and one double-width working register serve both operations. A multiply shifts right and conditionally adds the multiplicand, one partial product per cycle. A divide shifts left and trial-subtracts the divisor, one quotient bit per cycle. A partial remainder that would go negative is restored, and that step records a 0 bit. Signed operations work on operand magnitudes, and a last cycle applies the sign correction.

The surrounding pipeline pulses `start` with an operation code and two operands while the unit is idle. It then waits for the one-cycle `done` pulse and reads the result registers. After a multiply, the upper output holds the high half of the 64-bit product and the lower output holds the low half. After a divide, the upper output holds the remainder and the lower output holds the quotient. A zero divisor is reported on a status output and nothing traps.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `busy`, `done` and `divZero` are 0, and `hiOut` and `loOut` are 0.
- R2: With `op` = 1 (unsigned multiply), `{hiOut, loOut}` becomes the 64-bit unsigned product of `rsIn` and `rtIn`.
- R3: With `op` = 0 (signed multiply), `{hiOut, loOut}` becomes the 64-bit two's-complement product of `rsIn` and `rtIn`. The magnitude product is negated when the operand signs differ.
- R4: With `op` = 3 (unsigned divide) and a nonzero divisor `rtIn`, `loOut` becomes the quotient and `hiOut` the remainder.
- R5: With `op` = 2 (signed divide) and a nonzero divisor, the quotient is truncated toward zero and the remainder takes the sign of the dividend. Only the low 32 bits of a quotient are kept, so the most negative value divided by -1 gives 0x80000000.
- R6: A `start` seen while idle is accepted at that clock edge. `busy` is then high for exactly 33 cycles (32 iterations plus one sign-correction cycle). `done` is high for one cycle, right after `busy` falls, and never while `busy` is high.
- R7: `start` is ignored while `busy` is high. The running operation's result is unchanged, and no extra `done` pulse appears.
- R8: `divZero` is set when a divide (`op` 2 or 3) is accepted with `rtIn` = 0, and cleared when any other operation is accepted. In the divide-by-zero case `hiOut` and `loOut` hold steady after `done`.
- R9: `hiOut` and `loOut` keep the previous result while an operation runs, and change only in the cycle `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation (taken only while idle) |
| op | input | 2 | 0 signed multiply, 1 unsigned multiply, 2 signed divide, 3 unsigned divide |
| rsIn | input | 32 | First operand (multiplicand or dividend) |
| rtIn | input | 32 | Second operand (multiplier or divisor) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result registers just updated |
| divZero | output | 1 | Last accepted operation was a divide by zero |
| hiOut | output | 32 | Product high half, or remainder |
| loOut | output | 32 | Product low half, or quotient |

## Verification
Multiplies are driven with every sign combination, including the most negative value, all-ones and zero operands, so the product magnitude and the separate sign-correction step are each shown to be correct. Divides cover exact division, a dividend smaller than the divisor, a divisor of one and mixed signs, which separate a correct restore decision from a correct remainder sign. The overflowing signed quotient and the zero divisor probe the sign-fixup edges. A second start during an operation and the hold of HI/LO while the unit is busy show that the result registers are touched only at completion.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MUL_S = 2'd0,
    OP_MUL_U = 2'd1,
    OP_DIV_S = 2'd2,
    OP_DIV_U = 2'd3
  } mdOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
    logic fix;
  } mdStrobe_t;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int ITER = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output mdStrobe_t strobe,
  output logic      busy,
  output logic      done
);
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITER - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX} state_e;
  state_e state;
  logic [CW-1:0] iterCnt;

  always_comb begin
    strobe.load = (state == ST_IDLE) && start;
    strobe.step = (state == ST_RUN);
    strobe.fix  = (state == ST_FIX);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_RUN;
          iterCnt <= '0;
        end
        ST_RUN: begin
          iterCnt <= iterCnt + 1'b1;
          if (iterCnt == LAST) state <= ST_FIX;
        end
        ST_FIX: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  mdStrobe_t    strobe,
  input  logic [1:0]   op,
  input  logic [W-1:0] rsIn,
  input  logic [W-1:0] rtIn,
  output logic [W-1:0] hiOut,
  output logic [W-1:0] loOut,
  output logic         divZero
);
  localparam int AW = 2 * W;
  localparam int SW = W + 2;

  logic [AW-1:0] acc;
  logic [W-1:0]  opB;
  logic          isDiv, negHi, negLo;

  // operand magnitudes at load
  logic          isSignedIn, isDivIn, aNeg, bNeg;
  logic [W-1:0]  aMag, bMag;
  always_comb begin
    isDivIn    = op[1];
    isSignedIn = !op[0];
    aNeg       = isSignedIn && rsIn[W-1];
    bNeg       = isSignedIn && rtIn[W-1];
    aMag       = aNeg ? (~rsIn + 1'b1) : rsIn;
    bMag       = bNeg ? (~rtIn + 1'b1) : rtIn;
  end

  // single shared adder/subtractor
  logic [SW-1:0] addA, addB, addOut;
  always_comb begin
    addA   = isDiv ? {1'b0, acc[AW-1:W-1]} : {2'b00, acc[AW-1:W]};
    addB   = {2'b00, opB};
    addOut = isDiv ? (addA - addB) : (addA + addB);
  end

  // sign correction
  logic [AW-1:0] prodFix;
  logic [W-1:0]  remFix, quoFix;
  always_comb begin
    prodFix = negLo ? (~acc + 1'b1) : acc;
    remFix  = negHi ? (~acc[AW-1:W] + 1'b1) : acc[AW-1:W];
    quoFix  = negLo ? (~acc[W-1:0] + 1'b1) : acc[W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc     <= '0;
      opB     <= '0;
      isDiv   <= 1'b0;
      negHi   <= 1'b0;
      negLo   <= 1'b0;
      divZero <= 1'b0;
      hiOut   <= '0;
      loOut   <= '0;
    end else if (strobe.load) begin
      // divide: acc = dividend magnitude; multiply: acc = multiplier magnitude
      acc     <= {{W{1'b0}}, isDivIn ? aMag : bMag};
      opB     <= isDivIn ? bMag : aMag;
      isDiv   <= isDivIn;
      negLo   <= aNeg ^ bNeg;
      negHi   <= isDivIn && aNeg;
      divZero <= isDivIn && (rtIn == '0);
    end else if (strobe.step) begin
      if (isDiv) begin
        if (!addOut[SW-1]) acc <= {addOut[W-1:0], acc[W-2:0], 1'b1};
        else               acc <= {acc[AW-2:0], 1'b0};  // restore: keep old remainder
      end else begin
        if (acc[0]) acc <= {addOut[W:0], acc[W-1:1]};
        else        acc <= {1'b0, acc[AW-1:1]};
      end
    end else if (strobe.fix) begin
      if (isDiv) begin
        hiOut <= remFix;
        loOut <= quoFix;
      end else begin
        hiOut <= prodFix[AW-1:W];
        loOut <= prodFix[W-1:0];
      end
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] rsIn,
  input  logic [W-1:0] rtIn,
  output logic         busy,
  output logic         done,
  output logic         divZero,
  output logic [W-1:0] hiOut,
  output logic [W-1:0] loOut
);
  mdStrobe_t strobe;

  muldiv_ctrl #(.ITER(W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .strobe(strobe), .busy(busy), .done(done)
  );

  muldiv_dp #(.W(W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .op(op),
    .rsIn(rsIn), .rtIn(rtIn),
    .hiOut(hiOut), .loOut(loOut), .divZero(divZero)
  );
endmodule

// File: rtl/muldiv_checker.sv
module muldiv_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         divZero,
  input logic [W-1:0] hiOut,
  input logic [W-1:0] loOut
);
  localparam int RUNLEN = W + 1;
  localparam int CNTW   = $clog2(RUNLEN + 2);

  logic [CNTW-1:0] busyCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_no_done_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);
  assert_accept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt < CNTW'(RUNLEN)));
  assert_fall_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done && ($past(busyCnt) == CNTW'(RUNLEN - 1))));
  assert_hilo_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(hiOut) && $stable(loOut)));
  assert_dz_change_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divZero) |-> $rose(busy));
endmodule

bind muldiv_unit muldiv_checker #(.W(W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .divZero(divZero), .hiOut(hiOut), .loOut(loOut)
);

// File: tb/muldiv_unit_tb_top.sv
module muldiv_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [W-1:0] rsIn = '0, rtIn = '0;
  logic busy, done, divZero;
  logic [W-1:0] hiOut, loOut;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [W-1:0] hi;
    logic [W-1:0] lo;
    logic         dz;
    string        tag;
  } exp_t;
  exp_t sbq[$];
  logic [W-1:0] lastHi = '0, lastLo = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  muldiv_unit #(.W(W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .rsIn(rsIn), .rtIn(rtIn),
    .busy(busy), .done(done), .divZero(divZero), .hiOut(hiOut), .loOut(loOut)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // reference model
  function automatic exp_t model(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    longint sa, sb, q, r;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    e.dz = 1'b0;
    case (o)
      2'd0: begin p = 64'(sa * sb); e.hi = p[63:32]; e.lo = p[31:0]; e.tag = "R3"; end
      2'd1: begin p = {32'b0, a} * {32'b0, b}; e.hi = p[63:32]; e.lo = p[31:0]; e.tag = "R2"; end
      2'd2: begin
        e.tag = "R5";
        if (b == 0) begin e.dz = 1'b1; e.hi = 'x; e.lo = 'x; e.tag = "R8"; end
        else begin q = sa / sb; r = sa % sb; e.hi = r[31:0]; e.lo = q[31:0]; end
      end
      default: begin
        e.tag = "R4";
        if (b == 0) begin e.dz = 1'b1; e.hi = 'x; e.lo = 'x; e.tag = "R8"; end
        else begin e.hi = a % b; e.lo = a / b; end
      end
    endcase
    return e;
  endfunction

  // driver
  task automatic runOp(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
    sbq.push_back(model(o, a, b));
    @(negedge clk);
    start = 1'b1; op = o; rsIn = a; rtIn = b;
    @(negedge clk);
    start = 1'b0;
    while (sbq.size() != 0) @(negedge clk);
  endtask

  // monitor
  int busyCycles = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (busy) busyCycles++;
      if (done) begin
        check(busyCycles == 33, "R6 busy length", busyCycles, 33);
        busyCycles = 0;
        if (sbq.size() == 0) begin
          check(1'b0, "R7 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(divZero == e.dz, {e.tag, " divZero"}, divZero, e.dz);
          if (!e.dz) begin
            check(hiOut == e.hi, {e.tag, " hi"}, hiOut, e.hi);
            check(loOut == e.lo, {e.tag, " lo"}, loOut, e.lo);
          end
        end
        lastHi = hiOut; lastLo = loOut;
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !divZero, "R1 flags", {busy, done, divZero}, 0);
    check(hiOut == 0 && loOut == 0, "R1 hilo", {hiOut, loOut}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 unsigned multiply
    runOp(2'd1, 32'd7, 32'd6);
    runOp(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    runOp(2'd1, 32'h8000_0000, 32'd2);
    runOp(2'd1, 32'd0, 32'h1234_5678);
    // R3 signed multiply
    runOp(2'd0, -32'sd7, 32'd6);
    runOp(2'd0, -32'sd3, -32'sd5);
    runOp(2'd0, 32'h8000_0000, 32'h8000_0000);
    runOp(2'd0, 32'h8000_0000, 32'hFFFF_FFFF);
    runOp(2'd0, 32'h1234_5678, -32'sd1);
    // R4 unsigned divide
    runOp(2'd3, 32'd74, 32'd8);
    runOp(2'd3, 32'd5, 32'd9);
    runOp(2'd3, 32'hFFFF_FFFF, 32'd1);
    runOp(2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFE);
    // R5 signed divide
    runOp(2'd2, -32'sd7, 32'd2);
    runOp(2'd2, 32'd7, -32'sd2);
    runOp(2'd2, -32'sd7, -32'sd2);
    runOp(2'd2, 32'h8000_0000, 32'hFFFF_FFFF);
    runOp(2'd2, 32'd100, 32'd10);

    // R8 divide by zero, then hold and clear
    runOp(2'd3, 32'd55, 32'd0);
    begin
      logic [W-1:0] h0, l0;
      h0 = hiOut; l0 = loOut;
      repeat (4) @(negedge clk);
      check(hiOut == h0 && loOut == l0, "R8 hold", {hiOut, loOut}, {h0, l0});
      check(divZero == 1'b1, "R8 flag held", divZero, 1);
    end
    runOp(2'd2, -32'sd9, 32'd0);
    runOp(2'd1, 32'd3, 32'd3);   // divZero must clear (model dz=0)

    // R7 start ignored while busy, R9 hold during run
    sbq.push_back(model(2'd1, 32'd1000, 32'd1000));
    @(negedge clk);
    start = 1'b1; op = 2'd1; rsIn = 32'd1000; rtIn = 32'd1000;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    check(busy && hiOut == lastHi && loOut == lastLo, "R9 hold while busy",
          {hiOut, loOut}, {lastHi, lastLo});
    start = 1'b1; op = 2'd3; rsIn = 32'd9; rtIn = 32'd0;
    @(negedge clk);
    start = 1'b0;
    while (sbq.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    check(!busy && !divZero, "R7 no second op", {busy, divZero}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule